// File: doc/BRIEF.md
# Pseudo-Static RAM Access Sequencer

This block sits between a synchronous host and an asynchronous, SRAM-style pseudo-static memory with a 20-bit word address and a 16-bit data bus. It runs one single-word or byte-masked read or write per request. The host raises a one-cycle request with a direction flag, a 2-bit byte enable, an address and write data. The sequencer answers with a one-cycle acknowledge and, for reads, the returned word. Every strobe width, setup time and access delay is given in nanoseconds. The block turns each into host clock cycles by rounding up against a clock-period parameter.

The memory hides its own refresh behind the asynchronous interface. That adds rules a plain SRAM never imposes. Chip enable is released after every access, so it can never stay low for the 1000 ns limit. Output enable is held high whenever a write pulse begins, because a low output enable there would start an unwanted internal read. Write enable and output enable are frozen for a short window after chip enable rises, so the device drops into standby promptly. The address is held for the whole minimum cycle time once an access starts. The bidirectional data bus is split into an output, an output enable and an input, so that the pad ring can build the tristate buffer.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is active and right after it, chip enable, write enable, output enable and both byte strobes are high (inactive), the data bus is not driven and the acknowledge is low.
- R2: A write pulls chip enable, write enable and the enabled byte strobes low together for ceil(45 ns / period) cycles, and never fewer than ceil(15 ns / period), which is 9 cycles at 5 ns. The address is presented one cycle earlier, with every strobe high.
- R3: Byte enable bit 0 selects the low strobe, which covers data bits 7:0. Byte enable bit 1 selects the high strobe, which covers data bits 15:8. A lane whose enable is 0 keeps its old memory contents on a write, and a write with both enables at 0 changes nothing.
- R4: A read holds write enable high and pulls chip enable, output enable and the enabled byte strobes low. The data bus is sampled on the clock edge ceil(60 ns / period) + 1 cycles after chip enable falls, which is 13 cycles at 5 ns. The sampled word is returned on the read data output with the acknowledge.
- R5: On a read, each lane whose byte enable is 0 returns zero on the read data output, whatever the memory drives on it.
- R6: The memory address does not change while chip enable is low, or during the hold period that follows, until the cycle time of at least 70 ns has elapsed.
- R7: Chip enable stays high for at least ceil(10 ns / period) cycles between accesses and is never low for 1000 ns or longer.
- R8: Write enable and output enable keep their values for ceil(10 ns / period) cycles after chip enable rises.
- R9: The data bus is driven from the first cycle of a write pulse through one cycle after the pulse ends, and at no other time. In particular it is never driven while output enable is low.
- R10: The acknowledge is high for exactly one cycle per accepted request. At the default timing it rises 15 cycles after the accepting clock edge for a write and 17 cycles after it for a read.
- R11: Output enable is high at the moment chip enable falls for a write. Before output enable falls for a read, write enable has been high for at least ceil(10 ns / period) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 2 | Byte enables, bit 0 low lane, bit 1 high lane |
| addr_i | input | 20 | Word address |
| wdata_i | input | 16 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, valid with ack_o |
| mem_addr_o | output | 20 | Memory address |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_lb_n_o | output | 1 | Low byte strobe, active low |
| mem_ub_n_o | output | 1 | High byte strobe, active low |
| mem_dq_o | output | 16 | Data bus output value |
| mem_dq_oe_o | output | 1 | Data bus output enable |
| mem_dq_i | input | 16 | Data bus input value |

## Verification
The bench drives full-word, low-lane, high-lane and empty-mask writes to one address, and reads back after each one. This separates correct lane steering from swapped, merged or ignored byte enables. Reads of unwritten locations, and back-to-back mixes of writes and reads across the address range, show whether the address is held and the data returned against an independent reference memory. The memory model drives the inverted word until 60 ns after chip enable falls, and a rogue pattern on unselected lanes. A capture that comes too early, or a missing lane mask, therefore shows up as wrong read data rather than passing silently. Strobe widths, high times, hold windows and data-bus ownership are measured on the memory side for every access.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_TAIL,
    ST_REST
  } psram_st_e;

  function automatic int ns2cyc(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_cycle_cnt.sv
module psram_cycle_cnt #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/psram_dpath.sv
module psram_dpath #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic            capture_i,
  input  logic            wr_i,
  input  logic [DW/8-1:0] be_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   dq_i,
  output logic            wr_o,
  output logic [DW/8-1:0] be_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   wdata_o,
  output logic [DW-1:0]   rdata_o
);

  localparam int NB = DW / 8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o    <= 1'b0;
      be_o    <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      wr_o    <= wr_i;
      be_o    <= be_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  // per-lane capture; unselected lanes read back as zero
  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        rdata_o[b*8 +: 8] <= '0;
      else if (capture_i) rdata_o[b*8 +: 8] <= be_o[b] ? dq_i[b*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_pkg::*;
#(
  parameter int W       = 5,
  parameter int WR_ACT  = 9,
  parameter int RD_ACT  = 13,
  parameter int TAIL    = 2,
  parameter int WR_REST = 3,
  parameter int RD_REST = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic         wr_i,
  input  logic [1:0]   be_i,
  input  logic         done_i,
  output logic         load_o,
  output logic [W-1:0] load_val_o,
  output logic         accept_o,
  output logic         capture_o,
  output logic         ack_o,
  output logic         ce_n_o,
  output logic         we_n_o,
  output logic         oe_n_o,
  output logic         lb_n_o,
  output logic         ub_n_o,
  output logic         dq_oe_o
);

  psram_st_e state_q, state_d;
  logic      fin;
  logic      strobe_on;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    fin        = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        state_d  = ST_SETUP;
      end
      ST_SETUP: begin
        state_d    = ST_ACTIVE;
        load_o     = 1'b1;
        load_val_o = wr_i ? W'(WR_ACT - 1) : W'(RD_ACT - 1);
      end
      ST_ACTIVE: if (done_i) begin
        state_d    = ST_TAIL;
        load_o     = 1'b1;
        load_val_o = W'(TAIL - 1);
        capture_o  = !wr_i;
      end
      ST_TAIL: if (done_i) begin
        state_d    = ST_REST;
        load_o     = 1'b1;
        load_val_o = wr_i ? W'(WR_REST - 1) : W'(RD_REST - 1);
      end
      ST_REST: if (done_i) begin
        state_d = ST_IDLE;
        fin     = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // WE/OE/byte strobes stay put through TAIL after CE rises
  assign strobe_on = (state_d == ST_ACTIVE) || (state_d == ST_TAIL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      lb_n_o  <= 1'b1;
      ub_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
      ack_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n_o  <= (state_d != ST_ACTIVE);
      we_n_o  <= !(strobe_on && wr_i);
      oe_n_o  <= !(strobe_on && !wr_i);
      lb_n_o  <= !(strobe_on && be_i[0]);
      ub_n_o  <= !(strobe_on && be_i[1]);
      dq_oe_o <= wr_i && ((state_d == ST_ACTIVE) || (state_q == ST_ACTIVE));
      ack_o   <= fin;
    end
  end

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int CLK_NS      = 5,
  parameter int T_CYC_NS    = 70,
  parameter int T_CYC_MAX_NS = 1000,
  parameter int T_WP_NS     = 45,
  parameter int T_DS_NS     = 15,
  parameter int T_ACC_NS    = 60,
  parameter int T_CEHI_NS   = 10,
  parameter int T_STBY_NS   = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [1:0]    be_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_n_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic          mem_lb_n_o,
  output logic          mem_ub_n_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int WP_C    = max2(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
  localparam int RD_C    = ns2cyc(T_ACC_NS, CLK_NS) + 1;
  localparam int CYC_C   = ns2cyc(T_CYC_NS, CLK_NS);
  localparam int CEHI_C  = ns2cyc(T_CEHI_NS, CLK_NS);
  localparam int TAIL_C  = max2(1, ns2cyc(T_STBY_NS, CLK_NS));
  localparam int WREST_C = max2(1, max2(CEHI_C, CYC_C - WP_C) - TAIL_C);
  localparam int RREST_C = max2(1, max2(CEHI_C, CYC_C - RD_C) - TAIL_C);
  localparam int MAXLEN  = max2(max2(WP_C, RD_C), max2(TAIL_C, max2(WREST_C, RREST_C)));
  localparam int CNT_W   = $clog2(MAXLEN + 1);

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             done;
  logic             accept;
  logic             capture;
  logic             wr_q;
  logic [1:0]       be_q;

  psram_cycle_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .done_o (done)
  );

  psram_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .capture_i (capture),
    .wr_i      (wr_i),
    .be_i      (be_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .dq_i      (mem_dq_i),
    .wr_o      (wr_q),
    .be_o      (be_q),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_dq_o),
    .rdata_o   (rdata_o)
  );

  psram_seq #(
    .W       (CNT_W),
    .WR_ACT  (WP_C),
    .RD_ACT  (RD_C),
    .TAIL    (TAIL_C),
    .WR_REST (WREST_C),
    .RD_REST (RREST_C)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .wr_i       (wr_q),
    .be_i       (be_q),
    .done_i     (done),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .ack_o      (ack_o),
    .ce_n_o     (mem_ce_n_o),
    .we_n_o     (mem_we_n_o),
    .oe_n_o     (mem_oe_n_o),
    .lb_n_o     (mem_lb_n_o),
    .ub_n_o     (mem_ub_n_o),
    .dq_oe_o    (mem_dq_oe_o)
  );

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk
  import psram_pkg::*;
#(
  parameter int AW           = 20,
  parameter int CLK_NS       = 5,
  parameter int T_CYC_MAX_NS = 1000,
  parameter int T_WP_NS      = 45,
  parameter int T_DS_NS      = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_i,
  input logic [AW-1:0] addr_i,
  input logic          ce_n_i,
  input logic          we_n_i,
  input logic          oe_n_i,
  input logic          dq_oe_i
);

  localparam int WP_C  = max2(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
  localparam int MAX_C = T_CYC_MAX_NS / CLK_NS;
  localparam int LW    = $clog2(MAX_C + 2) + 1;

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_cnt <= '0;
    else if (!ce_n_i) low_cnt <= low_cnt + 1'b1;
    else              low_cnt <= '0;
  end

  a_r2_write_pulse_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ce_n_i) && !we_n_i) |-> (low_cnt >= LW'(WP_C)));

  a_r7_ce_low_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_n_i |-> (low_cnt < LW'(MAX_C)));

  a_r7_ce_high_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_n_i) |=> ce_n_i);

  a_r11_oe_high_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ce_n_i) && !we_n_i) |-> oe_n_i);

  a_r6_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_n_i |-> $stable(addr_i));

  a_r9_dq_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_i |-> (!we_n_i && oe_n_i));

  a_r10_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ack_i);

  a_r8_strobe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_n_i) |-> ($stable(we_n_i) && $stable(oe_n_i)));

endmodule

bind psram_ctrl psram_ctrl_chk #(
  .AW           (AW),
  .CLK_NS       (CLK_NS),
  .T_CYC_MAX_NS (T_CYC_MAX_NS),
  .T_WP_NS      (T_WP_NS),
  .T_DS_NS      (T_DS_NS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ack_i   (ack_o),
  .addr_i  (mem_addr_o),
  .ce_n_i  (mem_ce_n_o),
  .we_n_i  (mem_we_n_o),
  .oe_n_i  (mem_oe_n_o),
  .dq_oe_i (mem_dq_oe_o)
);

// File: tb/psram_ctrl_tb.sv
module psram_ctrl_tb;

  localparam int CLK_NS = 5;
  localparam int WP_C   = 9;
  localparam int CEHI_C = 2;
  localparam int HOLD_C = 2;
  localparam int MAX_C  = 200;
  localparam int ACC_NS = 60;

  typedef struct packed {
    logic        wr;
    logic [1:0]  be;
    logic [15:0] exp;
    logic [31:0] due;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  be_i = 2'b00;
  logic [19:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        ack_o;
  logic [15:0] rdata_o;
  logic [19:0] mem_addr_o;
  logic        mem_ce_n_o, mem_we_n_o, mem_oe_n_o, mem_lb_n_o, mem_ub_n_o;
  logic [15:0] mem_dq_o;
  logic        mem_dq_oe_o;
  logic [15:0] mem_dq_i = 16'hBEEF;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  logic [31:0] cyc = 0;
  bit          done = 0;

  item_t       sb_q[$];
  logic [15:0] model_m [logic [19:0]];
  logic [15:0] ref_m   [logic [19:0]];

  always #(CLK_NS * 500ps) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  psram_ctrl u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .req_i (req_i), .wr_i (wr_i), .be_i (be_i),
    .addr_i (addr_i), .wdata_i (wdata_i), .ack_o (ack_o), .rdata_o (rdata_o),
    .mem_addr_o (mem_addr_o), .mem_ce_n_o (mem_ce_n_o), .mem_we_n_o (mem_we_n_o),
    .mem_oe_n_o (mem_oe_n_o), .mem_lb_n_o (mem_lb_n_o), .mem_ub_n_o (mem_ub_n_o),
    .mem_dq_o (mem_dq_o), .mem_dq_oe_o (mem_dq_oe_o), .mem_dq_i (mem_dq_i)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_rd(logic [19:0] a);
    return model_m.exists(a) ? model_m[a] : (a[15:0] ^ 16'hA5A5);
  endfunction

  function automatic logic [15:0] ref_rd(logic [19:0] a);
    return ref_m.exists(a) ? ref_m[a] : (a[15:0] ^ 16'hA5A5);
  endfunction

  // memory model and bus-side timing monitor, sampled mid-cycle
  bit          p_ce = 1, p_we = 1, p_oe = 1, p_lb = 1, p_ub = 1;
  logic [15:0] p_dq;
  int          low = 0, ce_hi = 100, we_hi = 100;
  bit          drove = 1;
  logic [19:0] lock_a;
  bit          h_we = 1, h_oe = 1, was_wr = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (p_ce && !mem_ce_n_o) begin
        chk(ce_hi >= CEHI_C, "R7 ce high time", ce_hi, CEHI_C);
        if (!mem_we_n_o) chk(mem_oe_n_o, "R11 oe high at write start", mem_oe_n_o, 1);
        else             chk(we_hi >= 2, "R11 we high before read", we_hi, 2);
        lock_a = mem_addr_o;
        low = 0;
        drove = 1;
      end
      if (!mem_ce_n_o) begin
        low++;
        ce_hi = 0;
        chk(mem_addr_o == lock_a, "R6 address stable", mem_addr_o, lock_a);
        if (!mem_we_n_o && !mem_dq_oe_o) drove = 0;
        if (!mem_oe_n_o) chk(!mem_dq_oe_o, "R9 no drive during read", mem_dq_oe_o, 0);
      end
      if (!p_ce && mem_ce_n_o) begin
        chk(low < MAX_C, "R7 ce low limit", low, MAX_C);
        was_wr = !p_we;
        if (!p_we) begin
          chk(low >= WP_C, "R2 write pulse width", low, WP_C);
          chk(drove, "R9 drive during pulse", drove, 1);
          begin
            logic [15:0] w;
            w = model_rd(lock_a);
            if (!p_lb) w[7:0]  = p_dq[7:0];
            if (!p_ub) w[15:8] = p_dq[15:8];
            if (!p_lb || !p_ub) model_m[lock_a] = w;
          end
        end
        h_we = p_we;
        h_oe = p_oe;
      end
      if (mem_ce_n_o) begin
        ce_hi++;
        if (ce_hi <= HOLD_C) begin
          chk(mem_we_n_o == h_we, "R8 we hold", mem_we_n_o, h_we);
          chk(mem_oe_n_o == h_oe, "R8 oe hold", mem_oe_n_o, h_oe);
        end
        if (ce_hi == 2 && was_wr) chk(!mem_dq_oe_o, "R9 release after pulse", mem_dq_oe_o, 0);
      end
      if (mem_we_n_o) we_hi++; else we_hi = 0;
      if (!mem_ce_n_o && !mem_oe_n_o && mem_we_n_o) begin
        logic [15:0] d;
        d = model_rd(mem_addr_o);
        if (low * CLK_NS * 2 - CLK_NS >= 2 * ACC_NS) mem_dq_i = d;
        else                                         mem_dq_i = ~d;
        if (mem_lb_n_o) mem_dq_i[7:0]  = 8'hEF;
        if (mem_ub_n_o) mem_dq_i[15:8] = 8'hBE;
      end else begin
        mem_dq_i = 16'hBEEF;
      end
      p_ce = mem_ce_n_o; p_we = mem_we_n_o; p_oe = mem_oe_n_o;
      p_lb = mem_lb_n_o; p_ub = mem_ub_n_o; p_dq = mem_dq_o;
    end
  end

  // scoreboard monitor on the host side
  bit p_ack = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (p_ack && ack_o) chk(0, "R10 ack longer than one cycle", 1, 0);
      if (ack_o) begin
        if (sb_q.size() == 0) chk(0, "R10 unexpected ack", 1, 0);
        else begin
          item_t it;
          it = sb_q.pop_front();
          chk(cyc == it.due, "R10 ack latency", cyc, it.due);
          if (!it.wr)
            chk(rdata_o == it.exp, (it.be == 2'b11) ? "R4 read data" : "R5 masked read data",
                rdata_o, it.exp);
        end
      end
      p_ack = ack_o;
    end
  end

  task automatic access(bit wr, logic [19:0] a, logic [1:0] be, logic [15:0] d);
    item_t       it;
    logic [15:0] cur;
    cur = ref_rd(a);
    it.wr  = wr;
    it.be  = be;
    it.exp = {be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00};
    if (wr) begin
      if (be[0]) cur[7:0]  = d[7:0];
      if (be[1]) cur[15:8] = d[15:8];
      ref_m[a] = cur;
    end
    @(negedge clk);
    it.due = cyc + 1 + (wr ? 15 : 17);
    sb_q.push_back(it);
    req_i = 1; wr_i = wr; be_i = be; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 0; wdata_i = ~d;
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle levels held in reset
    chk(mem_ce_n_o && mem_we_n_o && mem_oe_n_o && mem_lb_n_o && mem_ub_n_o,
        "R1 strobes in reset", {mem_ce_n_o, mem_we_n_o, mem_oe_n_o, mem_lb_n_o, mem_ub_n_o}, 5'h1f);
    chk(!mem_dq_oe_o && !ack_o, "R1 bus and ack in reset", {mem_dq_oe_o, ack_o}, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(mem_ce_n_o && !mem_dq_oe_o && !ack_o, "R1 after reset", {mem_ce_n_o, mem_dq_oe_o, ack_o}, 4);

    access(1, 20'h00010, 2'b11, 16'h1234);   // R2 full word write
    access(0, 20'h00010, 2'b11, 16'h0);      // R4 read back
    access(1, 20'h00010, 2'b01, 16'hFFCD);   // R3 low lane only
    access(0, 20'h00010, 2'b11, 16'h0);
    access(1, 20'h00010, 2'b10, 16'h77EE);   // R3 high lane only
    access(0, 20'h00010, 2'b11, 16'h0);
    access(0, 20'h00010, 2'b01, 16'h0);      // R5 low lane read
    access(0, 20'h00010, 2'b10, 16'h0);      // R5 high lane read
    access(1, 20'h00010, 2'b00, 16'h5555);   // R3 empty mask write
    access(0, 20'h00010, 2'b11, 16'h0);
    access(0, 20'hFFFFF, 2'b11, 16'h0);      // R4 unwritten location
    for (int i = 0; i < 8; i++) begin
      access(1, 20'(i * 20'h11111), 2'b11, 16'(16'h0F0F ^ (i * 16'h1357)));
      access(0, 20'((7 - i) * 20'h11111), 2'b11, 16'h0);
    end
    for (int i = 0; i < 8; i++) access(0, 20'(i * 20'h11111), 2'b11, 16'h0);
    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R10 every request acknowledged", sb_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule